// File: doc/BRIEF.md
# Benchmark Run Control Sequencer

This block is the session controller on the master side of a traffic-generator benchmarking fabric. It leaves reset in configuration mode and holds a single global configuration-enable line high. Decoded host commands load the run and drain lengths, and relay trigger setups to addressed generators. A start command drops the enable line for a programmed number of cycles, so that benchmark traffic flows through the network under test.

When the run ends, the enable line rises again and a drain phase of programmed length follows. During the drain, readers keep emptying the network. The controller then polls every generator for its report, one address at a time from address 0, which is the master's own generator. It forwards each report word to the host stream. A generator that stays silent for too long is skipped and flagged. If a network monitor is configured, it is handed the host link and polled last. The controller then waits in a finished state.

States: CONFIG, RUN, DRAIN, REPORT_REQ, REPORT_WAIT, MONITOR and DONE. The transitions are:
- CONFIG to RUN on a start command.
- RUN to DRAIN when the run count expires.
- DRAIN to REPORT_REQ when the drain count expires.
- REPORT_REQ to REPORT_WAIT always, after one cycle.
- REPORT_WAIT to REPORT_REQ on a done strobe or a timeout, if generators remain to be polled.
- REPORT_WAIT to MONITOR, or to DONE when there is no monitor, after the last generator.
- MONITOR to DONE on a done strobe or a timeout.
- DONE to CONFIG on a start or a clear command.

Top module: `rcs_run_ctrl`

## Requirements
- R1: After reset, `cfg_en` is 1 and `rep_req`, `mon_sel`, `trig_valid`, `host_valid`, `node_err` and `mon_err` are all 0.
- R2: Command opcodes are 1 = set run length, 2 = set drain length, 3 = trigger setup, 4 = start and 5 = clear. In CONFIG, opcodes 1 and 2 load a 32-bit cycle count from `cmd_data`. In CONFIG, opcode 3 appears one cycle later on `trig_valid`, with `trig_addr`/`trig_data` equal to `cmd_addr`/`cmd_data`. Outside CONFIG, opcodes 1 to 3 have no effect.
- R3: A start command in CONFIG drives `cfg_en` to 0 from the next cycle. It stays 0 for exactly the run length in cycles, where a length of 0 counts as 1.
- R4: After `cfg_en` returns to 1, exactly the drain length in cycles passes before the first `rep_req`.
- R5: Each `rep_req` is a one-cycle pulse. `rep_addr` runs 0, 1, …, NUM_GEN-1. After a `rep_done` is sampled, the next request is high in the following cycle.
- R6: While a report is awaited, `rep_valid`/`rep_data` appear on `host_valid`/`host_data` one cycle later. In any other state, report input never reaches the host stream.
- R7: If no `rep_done` arrives within WAIT_LIMIT cycles after a request, bit `rep_addr` of `node_err` is set and stays set, and the next address is requested WAIT_LIMIT+1 cycles after the previous request.
- R8: With a monitor present, `mon_sel` is high after the last generator's report until `rep_done`. A silence of WAIT_LIMIT cycles instead sets `mon_err`. Both cases end in DONE with `mon_sel` low.
- R9: In DONE, start or clear returns to CONFIG without starting a run, and trigger setups are ignored. Clear in DONE and start in CONFIG both zero `node_err` and `mon_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Decoded host command present |
| cmd_op | input | 3 | Command opcode |
| cmd_addr | input | 7 | Target generator address for trigger setup |
| cmd_data | input | DATA_W | Length value or trigger payload |
| cfg_en | output | 1 | Global configuration enable, 0 only while running |
| trig_valid | output | 1 | Relayed trigger setup present |
| trig_addr | output | 7 | Relayed trigger target address |
| trig_data | output | DATA_W | Relayed trigger payload |
| rep_req | output | 1 | Report request pulse |
| rep_addr | output | 7 | Address of the polled generator |
| mon_sel | output | 1 | Monitor holds the host link and is being polled |
| rep_valid | input | 1 | Report word present |
| rep_data | input | DATA_W | Report word |
| rep_done | input | 1 | Current report is complete |
| host_valid | output | 1 | Host stream word present |
| host_data | output | DATA_W | Host stream word |
| node_err | output | NUM_GEN | Sticky per-generator timeout flags |
| mon_err | output | 1 | Sticky monitor timeout flag |

## Verification
The relayed trigger, the forwarded report word, the request after a done strobe and the fall of `cfg_en` after a start all show one cycle after the input is sampled. The bench drives on the falling edge and checks on the next falling edge. The run and drain windows are checked by counting falling edges on which `cfg_en` is low, and then counting those before the first request. Both counts must equal the programmed lengths. The timeout is checked the same way: the request-to-request distance must be WAIT_LIMIT+1, and the time `mon_sel` stays high must be WAIT_LIMIT.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

    localparam int ADDR_W = 7;

    typedef enum logic [2:0] {
        ST_CONFIG,
        ST_RUN,
        ST_DRAIN,
        ST_REPORT_REQ,
        ST_REPORT_WAIT,
        ST_MONITOR,
        ST_DONE
    } rcs_state_e;

    localparam logic [2:0] OP_SET_RUN   = 3'd1;
    localparam logic [2:0] OP_SET_DRAIN = 3'd2;
    localparam logic [2:0] OP_TRIG      = 3'd3;
    localparam logic [2:0] OP_START     = 3'd4;
    localparam logic [2:0] OP_CLEAR     = 3'd5;

endpackage

// File: rtl/rcs_phase_timer.sv
module rcs_phase_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         en,
    output logic         expire
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (en && cnt_q != '0)
            cnt_q <= cnt_q - W'(1);
    end

    // last cycle of the phase; zero length behaves like one
    assign expire = (cnt_q <= W'(1));
endmodule

// File: rtl/rcs_wait_timer.sv
module rcs_wait_timer #(
    parameter int LIMIT = 65535
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic timeout
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt_q <= '0;
        else if (en)
            cnt_q <= cnt_q + CW'(1);
    end

    assign timeout = en && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/rcs_stream_reg.sv
module rcs_stream_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            out_data  <= in_valid ? in_data : '0;
        end
    end
endmodule

// File: rtl/rcs_run_ctrl.sv
module rcs_run_ctrl
    import rcs_pkg::*;
#(
    parameter int NUM_GEN    = 4,
    parameter bit HAS_MON    = 1'b1,
    parameter int WAIT_LIMIT = 65535,
    parameter int DATA_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [6:0]        cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              cfg_en,
    output logic              trig_valid,
    output logic [6:0]        trig_addr,
    output logic [DATA_W-1:0] trig_data,
    output logic              rep_req,
    output logic [6:0]        rep_addr,
    output logic              mon_sel,
    input  logic              rep_valid,
    input  logic [DATA_W-1:0] rep_data,
    input  logic              rep_done,
    output logic              host_valid,
    output logic [DATA_W-1:0] host_data,
    output logic [NUM_GEN-1:0] node_err,
    output logic              mon_err
);
    localparam int TRIG_W = ADDR_W + DATA_W;
    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_GEN - 1);

    rcs_state_e state_q, state_d;
    logic [DATA_W-1:0] run_len_q, drain_len_q;
    logic [ADDR_W-1:0] idx_q;
    logic [NUM_GEN-1:0] node_err_q;
    logic mon_err_q;

    logic do_start, do_clear, do_trig, do_set_run, do_set_drain;
    logic in_cfg, waiting, last_node, phase_expire, wait_tmo, answer;
    logic tm_load;
    logic [DATA_W-1:0] tm_val;
    logic [TRIG_W-1:0] trig_bus;

    assign do_start     = cmd_valid && cmd_op == OP_START;
    assign do_clear     = cmd_valid && cmd_op == OP_CLEAR;
    assign do_trig      = cmd_valid && cmd_op == OP_TRIG;
    assign do_set_run   = cmd_valid && cmd_op == OP_SET_RUN;
    assign do_set_drain = cmd_valid && cmd_op == OP_SET_DRAIN;
    assign in_cfg       = state_q == ST_CONFIG;
    assign waiting      = state_q == ST_REPORT_WAIT || state_q == ST_MONITOR;
    assign last_node    = idx_q == LAST_IDX;
    assign answer       = rep_done || wait_tmo;

    // run and drain share one down counter
    assign tm_load = (in_cfg && do_start) || (state_q == ST_RUN && phase_expire);
    assign tm_val  = in_cfg ? run_len_q : drain_len_q;

    rcs_phase_timer #(.W(DATA_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .load(tm_load), .load_val(tm_val),
        .en(state_q == ST_RUN || state_q == ST_DRAIN), .expire(phase_expire)
    );

    rcs_wait_timer #(.LIMIT(WAIT_LIMIT)) u_wait (
        .clk(clk), .rst_n(rst_n), .clr(!waiting || answer),
        .en(waiting), .timeout(wait_tmo)
    );

    rcs_stream_reg #(.W(TRIG_W)) u_trig (
        .clk(clk), .rst_n(rst_n), .in_valid(in_cfg && do_trig),
        .in_data({cmd_addr, cmd_data}), .out_valid(trig_valid), .out_data(trig_bus)
    );
    assign trig_addr = trig_bus[TRIG_W-1 -: ADDR_W];
    assign trig_data = trig_bus[DATA_W-1:0];

    rcs_stream_reg #(.W(DATA_W)) u_host (
        .clk(clk), .rst_n(rst_n), .in_valid(waiting && rep_valid),
        .in_data(rep_data), .out_valid(host_valid), .out_data(host_data)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CONFIG:      if (do_start) state_d = ST_RUN;
            ST_RUN:         if (phase_expire) state_d = ST_DRAIN;
            ST_DRAIN:       if (phase_expire) state_d = ST_REPORT_REQ;
            ST_REPORT_REQ:  state_d = ST_REPORT_WAIT;
            ST_REPORT_WAIT: if (answer)
                                state_d = !last_node ? ST_REPORT_REQ :
                                          (HAS_MON ? ST_MONITOR : ST_DONE);
            ST_MONITOR:     if (answer) state_d = ST_DONE;
            ST_DONE:        if (do_start || do_clear) state_d = ST_CONFIG;
            default:        state_d = ST_CONFIG;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_CONFIG;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        cfg_en  = state_q != ST_RUN;
        rep_req = state_q == ST_REPORT_REQ;
        mon_sel = state_q == ST_MONITOR;
    end
    assign rep_addr = idx_q;
    assign node_err = node_err_q;
    assign mon_err  = mon_err_q;

    // lengths and poll cursor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len_q   <= '0;
            drain_len_q <= '0;
            idx_q       <= '0;
            mon_err_q   <= 1'b0;
        end else begin
            if (in_cfg && do_set_run)   run_len_q   <= cmd_data;
            if (in_cfg && do_set_drain) drain_len_q <= cmd_data;
            if (state_q == ST_DRAIN && phase_expire)
                idx_q <= '0;
            else if (state_q == ST_REPORT_WAIT && answer && !last_node)
                idx_q <= idx_q + ADDR_W'(1);
            if ((in_cfg && do_start) || (state_q == ST_DONE && do_clear))
                mon_err_q <= 1'b0;
            else if (state_q == ST_MONITOR && wait_tmo && !rep_done)
                mon_err_q <= 1'b1;
        end
    end

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_err
        always_ff @(posedge clk) begin
            if (!rst_n || (in_cfg && do_start) || (state_q == ST_DONE && do_clear))
                node_err_q[g] <= 1'b0;
            else if (state_q == ST_REPORT_WAIT && wait_tmo && !rep_done
                     && idx_q == ADDR_W'(g))
                node_err_q[g] <= 1'b1;
        end
    end
endmodule

// File: rtl/rcs_run_ctrl_chk.sv
module rcs_run_ctrl_chk #(
    parameter int NUM_GEN = 4,
    parameter int DATA_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic              cfg_en,
    input logic              trig_valid,
    input logic              rep_req,
    input logic [6:0]        rep_addr,
    input logic              mon_sel,
    input logic              rep_valid,
    input logic [DATA_W-1:0] rep_data,
    input logic              host_valid,
    input logic [DATA_W-1:0] host_data,
    input logic [NUM_GEN-1:0] node_err
);
    assert_trig_from_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trig_valid |-> $past(cmd_valid && cmd_op == 3'd3) && $past(cfg_en));

    assert_run_needs_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_en) |-> $past(cmd_valid && cmd_op == 3'd4));

    assert_req_outside_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rep_req |-> cfg_en && !mon_sel);

    assert_req_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rep_req |=> !rep_req);

    assert_req_addr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rep_req |-> int'(rep_addr) < NUM_GEN);

    assert_host_from_report_R6: assert property (@(posedge clk) disable iff (!rst_n)
        host_valid |-> $past(rep_valid) && host_data == $past(rep_data));

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(node_err) & ~node_err) != '0)
            |-> $past(cmd_valid && (cmd_op == 3'd4 || cmd_op == 3'd5)));
endmodule

bind rcs_run_ctrl rcs_run_ctrl_chk #(.NUM_GEN(NUM_GEN), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cfg_en(cfg_en), .trig_valid(trig_valid), .rep_req(rep_req),
    .rep_addr(rep_addr), .mon_sel(mon_sel), .rep_valid(rep_valid),
    .rep_data(rep_data), .host_valid(host_valid), .host_data(host_data),
    .node_err(node_err)
);

// File: tb/tb_rcs_run_ctrl.sv
module tb_rcs_run_ctrl;
    localparam int NG = 4;
    localparam int WL = 65535;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [6:0] cmd_addr = '0;
    logic [31:0] cmd_data = '0;
    logic rep_valid = 1'b0;
    logic [31:0] rep_data = '0;
    logic rep_done = 1'b0;
    logic cfg_en, trig_valid, rep_req, mon_sel, host_valid, mon_err;
    logic [6:0] trig_addr, rep_addr;
    logic [31:0] trig_data, host_data;
    logic [NG-1:0] node_err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    rcs_run_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cfg_en(cfg_en),
        .trig_valid(trig_valid), .trig_addr(trig_addr), .trig_data(trig_data),
        .rep_req(rep_req), .rep_addr(rep_addr), .mon_sel(mon_sel),
        .rep_valid(rep_valid), .rep_data(rep_data), .rep_done(rep_done),
        .host_valid(host_valid), .host_data(host_data),
        .node_err(node_err), .mon_err(mon_err)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [6:0]  addr;
        logic [31:0] data;
        logic        exp_v;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{3'd3, 7'd1,   32'hA5A5_0001, 1'b1},
        '{3'd1, 7'd0,   32'd10,        1'b0},
        '{3'd3, 7'd127, 32'hFFFF_FFFF, 1'b1},
        '{3'd2, 7'd0,   32'd5,         1'b0},
        '{3'd0, 7'd5,   32'h1234_5678, 1'b0},
        '{3'd3, 7'd0,   32'h0000_0000, 1'b1}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] op, input logic [6:0] a, input logic [31:0] d);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = '0; cmd_addr = '0; cmd_data = '0;
    endtask

    task automatic run_phase(input int exp_run, input int exp_drain, input string rr);
        int n = 0;
        int m = 0;
        while (cfg_en === 1'b0 && n < 1000) begin
            n++;
            if (n == 1) begin
                cmd_valid = 1'b1; cmd_op = 3'd3; cmd_addr = 7'd2; cmd_data = 32'h77;
                rep_valid = 1'b1; rep_data = 32'hBAD0_0001;
            end else if (n == 2) begin
                chk("R2 trig ignored in run", {63'd0, trig_valid}, 64'd0);
                chk("R6 no forward in run", {63'd0, host_valid}, 64'd0);
                rep_valid = 1'b0;
                cmd_op = 3'd1; cmd_data = 32'd99;
            end else if (n == 3) begin
                cmd_valid = 1'b0; cmd_op = '0; cmd_data = '0;
            end
            @(negedge clk);
        end
        chk({"R3 run length ", rr}, 64'(n), 64'(exp_run));
        while (rep_req !== 1'b1 && m < 1000) begin
            m++;
            @(negedge clk);
        end
        chk({"R4 drain length ", rr}, 64'(m), 64'(exp_drain));
    endtask

    task automatic serve(input int a);
        chk("R5 request high", {63'd0, rep_req}, 64'd1);
        chk("R5 request address", 64'(rep_addr), 64'(a));
        @(negedge clk);
        chk("R5 request one cycle", {63'd0, rep_req}, 64'd0);
        rep_valid = 1'b1; rep_data = 32'hD000_0000 + 32'(a);
        @(negedge clk);
        chk("R6 host valid", {63'd0, host_valid}, 64'd1);
        chk("R6 host data", 64'(host_data), 64'(32'hD000_0000 + 32'(a)));
        rep_valid = 1'b0; rep_done = 1'b1;
        @(negedge clk);
        rep_done = 1'b0;
    endtask

    initial begin
        @(posedge clk);
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                checks++; errors++;
                $display("FAIL watchdog actual=%0d expected=done", cyc);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cfg_en", {63'd0, cfg_en}, 64'd1);
        chk("R1 rep_req", {63'd0, rep_req}, 64'd0);
        chk("R1 mon_sel", {63'd0, mon_sel}, 64'd0);
        chk("R1 trig_valid", {63'd0, trig_valid}, 64'd0);
        chk("R1 host_valid", {63'd0, host_valid}, 64'd0);
        chk("R1 errors", 64'({mon_err, node_err}), 64'd0);

        // R2 table of configuration commands
        for (int i = 0; i < 6; i++) begin
            send(VECS[i].op, VECS[i].addr, VECS[i].data);
            chk("R2 trig valid", {63'd0, trig_valid}, {63'd0, VECS[i].exp_v});
            if (VECS[i].exp_v) begin
                chk("R2 trig addr", 64'(trig_addr), 64'(VECS[i].addr));
                chk("R2 trig data", 64'(trig_data), 64'(VECS[i].data));
            end
        end

        // first session: run 10, drain 5
        send(3'd4, 7'd0, 32'd0);
        run_phase(10, 5, "first");
        serve(0);
        serve(1);
        // node 2 stays silent: R7 timeout
        chk("R7 polled address", 64'(rep_addr), 64'd2);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (rep_req !== 1'b1 && k < 70000);
        chk("R7 timeout distance", 64'(k), 64'(WL + 1));
        chk("R7 next address", 64'(rep_addr), 64'd3);
        chk("R7 error flag", 64'(node_err), 64'b0100);
        serve(3);
        // R8 monitor answers
        chk("R8 monitor selected", {63'd0, mon_sel}, 64'd1);
        rep_valid = 1'b1; rep_data = 32'h0E0E_0E0E;
        @(negedge clk);
        chk("R8 monitor word forwarded", 64'(host_data), 64'h0E0E_0E0E);
        rep_valid = 1'b0; rep_done = 1'b1;
        @(negedge clk);
        rep_done = 1'b0;
        chk("R8 monitor released", {63'd0, mon_sel}, 64'd0);
        chk("R8 done with cfg_en high", {63'd0, cfg_en}, 64'd1);
        chk("R8 no monitor error", {63'd0, mon_err}, 64'd0);

        // R9 DONE state behaviour
        send(3'd3, 7'd4, 32'h55);
        chk("R9 trig ignored in done", {63'd0, trig_valid}, 64'd0);
        chk("R7 flag sticky in done", 64'(node_err), 64'b0100);
        send(3'd4, 7'd0, 32'd0);
        chk("R9 start in done does not run", {63'd0, cfg_en}, 64'd1);
        @(negedge clk);
        chk("R9 still configuring", {63'd0, cfg_en}, 64'd1);
        chk("R9 flags kept by start in done", 64'(node_err), 64'b0100);

        // second session: drain 2, run length must still be 10 (R2)
        send(3'd2, 7'd0, 32'd2);
        send(3'd4, 7'd0, 32'd0);
        chk("R9 start clears flags", 64'(node_err), 64'd0);
        run_phase(10, 2, "second");
        for (int a = 0; a < NG; a++) serve(a);
        chk("R8 monitor selected again", {63'd0, mon_sel}, 64'd1);
        k = 0;
        while (mon_sel === 1'b1 && k < 70000) begin
            @(negedge clk);
            k++;
        end
        chk("R8 monitor timeout length", 64'(k), 64'(WL));
        chk("R8 monitor error", {63'd0, mon_err}, 64'd1);
        send(3'd5, 7'd0, 32'd0);
        chk("R9 clear zeroes monitor error", {63'd0, mon_err}, 64'd0);
        chk("R9 clear zeroes node flags", 64'(node_err), 64'd0);
        send(3'd3, 7'd9, 32'hC0DE);
        chk("R9 back in config relays trig", {63'd0, trig_valid}, 64'd1);
        chk("R9 relayed addr", 64'(trig_addr), 64'd9);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule